// File: doc/BRIEF.md
# Sixteen-Bit Timer with Selectable Wrap Point

This block is a 16-bit up-counter. A three-bit mode field picks where the counter wraps back to zero. The wrap point can be the full 16-bit range, a fixed 8-, 9- or 10-bit limit, the compare A register or the capture register. Two compare channels set match flags and drive single-slope PWM outputs. A capture channel stores the running count when a chosen edge appears on an external pin. That pin can pass through an optional four-sample glitch filter.

A host reaches the block through a byte-wide register port. The 16-bit values are split into an even low-byte address and an odd high-byte address, and one shared staging byte makes each 16-bit transfer atomic. Address map: 0 control, 1 flags, 2/3 counter, 4/5 compare A, 6/7 compare B, 8/9 capture. Addresses 10 to 15 read as zero. The control byte holds:
- bits [2:0]: mode
- bit 3: filter enable
- bit 4: capture edge, 1 for rising and 0 for falling
- bit 5: run

The flags byte holds:
- bit 0: wrap
- bit 1: overflow
- bit 2: match A
- bit 3: match B
- bit 4: capture

Top module: `timer16`

## Requirements
- R1: After reset the control byte, the flags, the counter and every 16-bit register are zero, and both PWM outputs are low.
- R2: In modes 0, 6 and 7 the wrap point is 0xFFFF. On any clock where the counter runs while holding 0xFFFF, it steps to 0x0000 and sets overflow flag bit 1.
- R3: Modes 1, 2 and 3 wrap at 0x00FF, 0x01FF and 0x03FF. On a clock where the running counter equals its wrap point, the counter goes to zero and wrap flag bit 0 is set.
- R4: Mode 4 uses the active compare A value as the wrap point. In this mode, host writes to compare A land in a buffer that is copied to the active value only on a wrap. pwm_a stays low in this mode.
- R5: Mode 5 uses the capture register as the wrap point. In this mode the capture register changes only through host writes, and no capture event is raised.
- R6: While running, a counter value equal to compare A sets flag bit 2, and a counter value equal to compare B sets flag bit 3.
- R7: With the filter off, an edge of cap_in in the direction chosen by control bit 4 copies the count into the capture register and sets flag bit 4 two clocks after the pin changes. An edge in the other direction has no effect.
- R8: With control bit 3 set, a new cap_in level counts only after four consecutive samples at that level. Shorter pulses cause no capture, and an accepted edge is seen three clocks later than with the filter off.
- R9: Writing an odd (high) address loads the staging byte, and writing the matching even address commits the staging byte and the written byte together. Reading an even address with rd_en latches that register's high byte into the staging byte, and odd addresses read the staging byte.
- R10: Writing the flags address clears each flag whose written bit is 1. A flag being set on the same clock wins over the clear.
- R11: In modes 1, 2, 3 and 5, pwm_a is high while count < compare A. In modes 1 to 5, pwm_b is high while count < compare B. Both outputs are low in modes 0, 6 and 7.
- R12: With the run bit clear, the counter holds its value except when the host writes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (low-byte side effect) |
| addr | input | 4 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational from addr |
| cap_in | input | 1 | External capture input |
| pwm_a | output | 1 | Compare A PWM output |
| pwm_b | output | 1 | Compare B PWM output |
| flags | output | 5 | Wrap, overflow, match A, match B, capture flags |

## Verification
The assertions assume that the host never raises wr_en and rd_en on the same clock. They also assume that cap_in is low when reset is released, so no capture edge appears from reset itself. The stimulus drives every input on the falling edge and keeps the two strobes mutually exclusive. It reads 16-bit values low byte first, and it mostly reloads the counter while the run bit is clear, so directed results do not depend on how long a bus transfer takes.

// File: rtl/timer16.sv
module timer16 #(
  parameter int FILT = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [3:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic       cap_in,
  output logic       pwm_a,
  output logic       pwm_b,
  output logic [4:0] flags
);
  localparam int HW = FILT - 1;

  logic [5:0]    ctrl;
  logic [15:0]   cnt, ocra, ocra_buf, ocrb, icr, top, a_eff;
  logic [7:0]    tmp;
  logic          cap_s, lvl, new_lvl, cap_evt, wrap, run;
  logic [HW-1:0] hist;
  logic [2:0]    mode;
  logic [4:0]    fl, fset, fclr;

  assign mode  = ctrl[2:0];
  assign run   = ctrl[5];
  assign a_eff = (mode == 3'd4) ? ocra : ocra_buf;

  always_comb begin
    case (mode)
      3'd1:    top = 16'h00FF;
      3'd2:    top = 16'h01FF;
      3'd3:    top = 16'h03FF;
      3'd4:    top = ocra;
      3'd5:    top = icr;
      default: top = 16'hFFFF;
    endcase
  end

  assign wrap    = run && (cnt == top);
  assign new_lvl = !ctrl[3] ? cap_s : ((hist == {HW{cap_s}}) ? cap_s : lvl);
  assign cap_evt = (new_lvl != lvl) && (new_lvl == ctrl[4]) && (mode != 3'd5);

  assign fset = {cap_evt, run && (cnt == ocrb), run && (cnt == a_eff),
                 run && (cnt == 16'hFFFF), wrap};
  assign fclr = (wr_en && addr == 4'd1) ? wdata[4:0] : 5'd0;
  assign flags = fl;

  assign pwm_a = (mode inside {3'd1, 3'd2, 3'd3, 3'd5}) && (cnt < a_eff);
  assign pwm_b = (mode inside {3'd1, 3'd2, 3'd3, 3'd4, 3'd5}) && (cnt < ocrb);

  always_comb begin
    case (addr)
      4'd0:    rdata = {2'b00, ctrl};
      4'd1:    rdata = {3'b000, fl};
      4'd2:    rdata = cnt[7:0];
      4'd4:    rdata = ocra_buf[7:0];
      4'd6:    rdata = ocrb[7:0];
      4'd8:    rdata = icr[7:0];
      4'd3, 4'd5, 4'd7, 4'd9: rdata = tmp;
      default: rdata = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl <= '0; cnt <= '0; ocra <= '0; ocra_buf <= '0; ocrb <= '0; icr <= '0;
      tmp <= '0; cap_s <= 1'b0; lvl <= 1'b0; hist <= '0; fl <= '0;
    end else begin
      cap_s <= cap_in;
      hist  <= {hist[HW-2:0], cap_s};
      lvl   <= new_lvl;
      fl    <= (fl & ~fclr) | fset;

      if (wr_en && addr == 4'd0) ctrl <= wdata[5:0];

      if (wr_en && addr == 4'd2) cnt <= {tmp, wdata};
      else if (run)              cnt <= wrap ? 16'd0 : cnt + 16'd1;

      if (wr_en && addr == 4'd4) ocra_buf <= {tmp, wdata};
      if (mode != 3'd4 || wrap)  ocra <= ocra_buf;

      if (wr_en && addr == 4'd6) ocrb <= {tmp, wdata};

      if (wr_en && addr == 4'd8) icr <= {tmp, wdata};
      else if (cap_evt)          icr <= cnt;

      if (wr_en && (addr inside {4'd3, 4'd5, 4'd7, 4'd9}))
        tmp <= wdata;
      else if (rd_en && !wr_en) begin
        case (addr)
          4'd2:    tmp <= cnt[15:8];
          4'd4:    tmp <= ocra_buf[15:8];
          4'd6:    tmp <= ocrb[15:8];
          4'd8:    tmp <= icr[15:8];
          default: tmp <= tmp;
        endcase
      end
    end
  end
endmodule

// File: rtl/timer16_chk.sv
module timer16_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [3:0]  addr,
  input logic [5:0]  ctrl,
  input logic [15:0] cnt,
  input logic [15:0] ocra,
  input logic [15:0] ocrb,
  input logic [15:0] icr,
  input logic [4:0]  flags
);
  AST_FIXED8_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[5] && ctrl[2:0] == 3'd1 && cnt == 16'h00FF && !(wr_en && addr == 4'd2)) |=> cnt == 16'd0); // R3
  AST_MAX_SETS_OVF: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[5] && cnt == 16'hFFFF) |=> flags[1]); // R2
  AST_ACTIVE_A_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[2:0] == 3'd4 && !(ctrl[5] && cnt == ocra)) |=> $stable(ocra)); // R4
  AST_ICR_TOP_NO_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[2:0] == 3'd5 && !(wr_en && addr == 4'd8)) |=> $stable(icr)); // R5
  AST_MATCH_B_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[5] && cnt == ocrb) |=> flags[3]); // R6
  AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl[5] && !(wr_en && addr == 4'd2)) |=> $stable(cnt)); // R12
endmodule

bind timer16 timer16_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .ctrl(ctrl),
  .cnt(cnt), .ocra(ocra), .ocrb(ocrb), .icr(icr), .flags(flags)
);

// File: tb/timer16_tb.sv
module timer16_tb;
  localparam int CLK_P = 10;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, rd_en = 1'b0, cap_in = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic pwm_a, pwm_b;
  logic [4:0] flags;

  int checks = 0, fails = 0;
  bit done = 0;

  timer16 u_dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
                 .wdata(wdata), .rdata(rdata), .cap_in(cap_in), .pwm_a(pwm_a),
                 .pwm_b(pwm_b), .flags(flags));

  always #(CLK_P/2) clk = ~clk;

  // behavioural reference model
  logic [5:0]  m_ctrl;
  logic [4:0]  m_fl, n_fl, setv, clrv;
  logic [15:0] m_cnt, m_abuf, m_aact, m_b, m_icr, n_cnt, n_abuf, n_aact, n_b, n_icr, top, aeff;
  logic [7:0]  m_tmp, n_tmp;
  logic        m_samp, m_lvl, nlvl, cap, wrp, runb;
  int          m_runlen;

  function automatic logic [15:0] wrap_point(input logic [2:0] md, input logic [15:0] a, input logic [15:0] c);
    case (md)
      3'd1: return 16'h00FF;
      3'd2: return 16'h01FF;
      3'd3: return 16'h03FF;
      3'd4: return a;
      3'd5: return c;
      default: return 16'hFFFF;
    endcase
  endfunction

  function automatic logic [7:0] m_rd(input logic [3:0] a);
    case (a)
      4'd0: return {2'b00, m_ctrl};
      4'd1: return {3'b000, m_fl};
      4'd2: return m_cnt[7:0];
      4'd4: return m_abuf[7:0];
      4'd6: return m_b[7:0];
      4'd8: return m_icr[7:0];
      4'd3, 4'd5, 4'd7, 4'd9: return m_tmp;
      default: return 8'h00;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ctrl = '0; m_fl = '0; m_cnt = '0; m_abuf = '0; m_aact = '0; m_b = '0; m_icr = '0;
      m_tmp = '0; m_samp = 0; m_lvl = 0; m_runlen = 4;
    end else begin
      runb = m_ctrl[5];
      top  = wrap_point(m_ctrl[2:0], m_aact, m_icr);
      aeff = (m_ctrl[2:0] == 3'd4) ? m_aact : m_abuf;
      wrp  = runb && (m_cnt == top);
      if (!m_ctrl[3] || m_runlen >= 4) nlvl = m_samp; else nlvl = m_lvl;
      cap  = (nlvl != m_lvl) && (nlvl == m_ctrl[4]) && (m_ctrl[2:0] != 3'd5);
      setv = {cap, runb && m_cnt == m_b, runb && m_cnt == aeff, runb && m_cnt == 16'hFFFF, wrp};
      clrv = (wr_en && addr == 4'd1) ? wdata[4:0] : 5'd0;
      n_fl = (m_fl & ~clrv) | setv;
      n_cnt = m_cnt;
      if (wr_en && addr == 4'd2) n_cnt = {m_tmp, wdata};
      else if (runb) n_cnt = wrp ? 16'd0 : m_cnt + 16'd1;
      n_abuf = (wr_en && addr == 4'd4) ? {m_tmp, wdata} : m_abuf;
      n_aact = (m_ctrl[2:0] != 3'd4 || wrp) ? m_abuf : m_aact;
      n_b    = (wr_en && addr == 4'd6) ? {m_tmp, wdata} : m_b;
      n_icr  = m_icr;
      if (wr_en && addr == 4'd8) n_icr = {m_tmp, wdata};
      else if (cap) n_icr = m_cnt;
      n_tmp = m_tmp;
      if (wr_en && (addr == 4'd3 || addr == 4'd5 || addr == 4'd7 || addr == 4'd9)) n_tmp = wdata;
      else if (rd_en && !wr_en) begin
        if (addr == 4'd2) n_tmp = m_cnt[15:8];
        if (addr == 4'd4) n_tmp = m_abuf[15:8];
        if (addr == 4'd6) n_tmp = m_b[15:8];
        if (addr == 4'd8) n_tmp = m_icr[15:8];
      end
      if (wr_en && addr == 4'd0) m_ctrl = wdata[5:0];
      m_runlen = (cap_in == m_samp) ? ((m_runlen < 8) ? m_runlen + 1 : 8) : 1;
      m_samp = cap_in; m_lvl = nlvl;
      m_fl = n_fl; m_cnt = n_cnt; m_abuf = n_abuf; m_aact = n_aact; m_b = n_b;
      m_icr = n_icr; m_tmp = n_tmp;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // every-clock comparison against the model
  logic ea, eb;
  always begin
    @(posedge clk); #(CLK_P/4);
    if (rst_n && !done) begin
      aeff = (m_ctrl[2:0] == 3'd4) ? m_aact : m_abuf;
      ea = (m_ctrl[2:0] inside {3'd1, 3'd2, 3'd3, 3'd5}) && (m_cnt < aeff);
      eb = (m_ctrl[2:0] inside {3'd1, 3'd2, 3'd3, 3'd4, 3'd5}) && (m_cnt < m_b);
      check(rdata == m_rd(addr), "R9 rdata", rdata, m_rd(addr));
      check(flags == m_fl, "R6 flags", flags, m_fl);
      check(pwm_a == ea, "R11 pwm_a", pwm_a, ea);
      check(pwm_b == eb, "R11 pwm_b", pwm_b, eb);
    end
  end

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0; addr = 4'd0;
  endtask

  task automatic wr16(input logic [3:0] lo, input logic [15:0] v);
    wr(lo + 4'd1, v[15:8]); wr(lo, v[7:0]);
  endtask

  task automatic rd8(input logic [3:0] a, output logic [7:0] v);
    @(negedge clk); addr = a; #1 v = rdata;
  endtask

  task automatic rd16(input logic [3:0] lo, output logic [15:0] v);
    @(negedge clk); addr = lo; rd_en = 1; #1 v[7:0] = rdata;
    @(negedge clk); rd_en = 0; addr = lo + 4'd1; #1 v[15:8] = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run;
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  logic [7:0]  b8;
  logic [15:0] v16;

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    // R1
    rd8(4'd0, b8); check(b8 == 8'h00, "R1 ctrl", b8, 0);
    rd8(4'd1, b8); check(b8 == 8'h00, "R1 flags", b8, 0);
    rd16(4'd2, v16); check(v16 == 16'h0, "R1 count", v16, 0);
    check(!pwm_a && !pwm_b, "R1 pwm", {pwm_a, pwm_b}, 0);
    // R9
    wr16(4'd2, 16'h1234); rd16(4'd2, v16); check(v16 == 16'h1234, "R9 count", v16, 16'h1234);
    wr16(4'd6, 16'hABCD); rd16(4'd6, v16); check(v16 == 16'hABCD, "R9 cmpB", v16, 16'hABCD);
    // R12
    idle(6); rd16(4'd2, v16); check(v16 == 16'h1234, "R12 hold", v16, 16'h1234);
    // R3 fixed wrap points
    wr16(4'd2, 16'h00FD); wr(4'd0, 8'h21); idle(10); wr(4'd0, 8'h01);
    rd8(4'd1, b8); check(b8[0] && !b8[1], "R3 8-bit wrap", b8, 1);
    rd16(4'd2, v16); check(v16 < 16'h20, "R3 8-bit count", v16, m_cnt);
    wr(4'd1, 8'h1F); rd8(4'd1, b8); check(b8 == 8'h00, "R10 clear", b8, 0);
    wr16(4'd2, 16'h01FD); wr(4'd0, 8'h22); idle(10); wr(4'd0, 8'h02);
    rd16(4'd2, v16); check(v16 < 16'h20, "R3 9-bit count", v16, m_cnt);
    wr16(4'd2, 16'h03FD); wr(4'd0, 8'h23); idle(10); wr(4'd0, 8'h03);
    rd16(4'd2, v16); check(v16 < 16'h20, "R3 10-bit count", v16, m_cnt);
    wr(4'd1, 8'h1F);
    // R2
    wr16(4'd2, 16'hFFFD); wr(4'd0, 8'h20); idle(10); wr(4'd0, 8'h00);
    rd8(4'd1, b8); check(b8[1:0] == 2'b11, "R2 overflow", b8, 3);
    rd16(4'd2, v16); check(v16 < 16'h20, "R2 count", v16, m_cnt);
    wr(4'd1, 8'h1F);
    // R6
    wr16(4'd4, 16'h0010); wr16(4'd6, 16'h0020); wr16(4'd2, 16'h0000);
    wr(4'd0, 8'h21); idle(40); wr(4'd0, 8'h01);
    rd8(4'd1, b8); check(b8[3:2] == 2'b11, "R6 matches", b8, 8'h0C);
    wr(4'd1, 8'h1F);
    // R11
    wr16(4'd4, 16'h0080); wr16(4'd6, 16'h0040); wr16(4'd2, 16'h0050); idle(1);
    check(pwm_a && !pwm_b, "R11 mode1 pwm", {pwm_a, pwm_b}, 2'b10);
    wr(4'd0, 8'h00); idle(1);
    check(!pwm_a && !pwm_b, "R11 mode0 pwm", {pwm_a, pwm_b}, 0);
    // R4 buffered wrap point
    wr16(4'd4, 16'h0010); wr(4'd0, 8'h04); wr16(4'd2, 16'h0005); idle(1);
    check(!pwm_a, "R4 pwm_a low", pwm_a, 0);
    wr16(4'd4, 16'h0008); wr(4'd0, 8'h24); idle(16); wr(4'd0, 8'h04);
    rd8(4'd1, b8); check(b8[0], "R4 wrap at old value", b8, 1);
    rd16(4'd2, v16); check(v16 <= 16'h0008, "R4 new value applied", v16, m_cnt);
    wr(4'd1, 8'h1F);
    // R5
    wr16(4'd8, 16'h0018); wr16(4'd4, 16'h0008); wr16(4'd2, 16'h0000);
    wr(4'd0, 8'h35); idle(40);
    @(negedge clk); cap_in = 1; idle(6); cap_in = 0; idle(6); wr(4'd0, 8'h15);
    rd16(4'd8, v16); check(v16 == 16'h0018, "R5 capture frozen", v16, 16'h0018);
    rd8(4'd1, b8); check(!b8[4], "R5 no capture flag", b8, 0);
    rd16(4'd2, v16); check(v16 <= 16'h0018, "R5 wrap point", v16, 16'h0018);
    wr16(4'd2, 16'h0002); idle(1);
    check(pwm_a, "R5 pwm_a active", pwm_a, 1);
    wr(4'd1, 8'h1F);
    // R7
    wr16(4'd2, 16'h0100); wr(4'd0, 8'h30);
    @(negedge clk); cap_in = 1; idle(4);
    rd8(4'd1, b8); check(b8[4], "R7 rising capture", b8, 8'h10);
    rd16(4'd8, v16); check(v16 == m_icr, "R7 capture value", v16, m_icr);
    wr(4'd1, 8'h10); wr(4'd0, 8'h20);
    @(negedge clk); cap_in = 0; idle(4);
    rd8(4'd1, b8); check(b8[4], "R7 falling capture", b8, 8'h10);
    wr(4'd1, 8'h10);
    @(negedge clk); cap_in = 1; idle(4);
    rd8(4'd1, b8); check(!b8[4], "R7 wrong edge ignored", b8, 0);
    @(negedge clk); cap_in = 0; idle(4); wr(4'd1, 8'h1F);
    // R8
    wr(4'd0, 8'h38);
    @(negedge clk); cap_in = 1; idle(2); cap_in = 0; idle(8);
    rd8(4'd1, b8); check(!b8[4], "R8 glitch rejected", b8, 0);
    cap_in = 1; idle(8);
    rd8(4'd1, b8); check(b8[4], "R8 steady edge", b8, 8'h10);
    rd16(4'd8, v16); check(v16 == m_icr, "R8 capture value", v16, m_icr);
    idle(4);
    finish_run();
  end
endmodule